// File: doc/BRIEF.md
# Banked ROM/RAM Mapper with Mode Select

This block sits on the cartridge side of an 8-bit CPU bus. It watches CPU writes to the read-only area at 0x0000–0x7FFF and turns them into mapper state: an external RAM enable flag, a 7-bit ROM bank number and a 2-bit RAM bank number. It drives the bank for the switchable 16 KiB ROM window and the bank for the 8 KiB external RAM window. It also drives a chip enable for the external RAM.

The write is decoded by CPU address bits [15:13]. A 2-bit register is shared between two uses. A mode bit decides whether it supplies ROM bank bits [6:5] or picks the RAM bank. Changing the mode also rewrites the bank that the new mode no longer uses.

The ROM holds a power-of-two number of banks, set by a parameter. A bank number past the end of the ROM wraps back into range.

Top module: `bank_mapper`

## Requirements
- R1: After reset, the ROM bank output is 1, the RAM bank output is 0, the mode is 0 and external RAM is disabled.
- R2: A write to region 0 (address bits [15:13] = 000) with data 0x0A sets the RAM enable flag. Data 0x00 clears it. Any other data value leaves the flag unchanged.
- R3: A write to region 1 (bits [15:13] = 001) loads data bits [4:0] into ROM bank bits [4:0]. Data bits [7:5] are ignored and ROM bank bits [6:5] are kept.
- R4: A region 1 write whose data bits [4:0] are zero loads ROM bank bits [4:0] with 1.
- R5: In mode 0, a write to region 2 (bits [15:13] = 010) loads data bits [1:0] into ROM bank bits [6:5]. ROM bank bits [4:0] are kept and the RAM bank is not changed.
- R6: In mode 1, a write to region 2 loads data bits [1:0] into the RAM bank and leaves the ROM bank unchanged.
- R7: A write to region 3 (bits [15:13] = 011) sets the mode from data bit 0. When data bit 0 is 1, ROM bank bits [6:5] are cleared and the RAM bank is kept.
- R8: A region 3 write with data bit 0 equal to 0 sets the RAM bank to 0 and keeps the ROM bank.
- R9: The ROM bank output equals the 7-bit ROM bank number ANDed with (ROM_BANKS − 1). Bits at and above log2(ROM_BANKS) are therefore zero.
- R10: The RAM chip enable is high only while the enable flag is set and address bits [15:13] are 101 (0xA000–0xBFFF).
- R11: A write with address bit 15 set, or any cycle with the write strobe low, changes no mapper state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| addr_top | input | 3 | CPU address bits [15:13] |
| wdata | input | 8 | CPU write data |
| rom_bank_o | output | 7 | Wrapped bank for the switchable ROM window |
| ram_bank_o | output | 2 | Bank for the external RAM window |
| ram_ce_o | output | 1 | External RAM chip enable |

## Verification
The bench targets the following failure modes:
- **Zero substitution in region 1.** It writes region 1 with a value whose low five bits are zero but whose upper bits are set. A design that tests the whole byte for zero would select bank 0 instead of bank 1.
- **Mode switching.** It sets the upper ROM bits and then enters mode 1. A mapper that failed to clear them would still show them after wrapping. Leaving mode 1 with a nonzero RAM bank exposes a design that forgets to force the RAM bank to zero.
- **Wrap mask.** It loads bank 0x7F with a 64-bank ROM. A wrong mask would let bit 6 through.
- **Ignored writes and enable values.** Writes to the upper half of the address space must change nothing. The same applies to cycles with the strobe low and to enable values other than 0x00 and 0x0A. A careless decoder would show any of these as a change in bank or chip enable.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int LOW_W  = 5;
  localparam int HI_W   = 2;
  localparam int BANK_W = LOW_W + HI_W;
  localparam int RSEL_W = 2;
  localparam int NRGN   = 4;
  localparam logic [7:0] EN_KEY  = 8'h0A;
  localparam logic [7:0] DIS_KEY = 8'h00;
  localparam logic [2:0] RAM_WIN = 3'b101;

  function automatic logic [LOW_W-1:0] fix_low(input logic [LOW_W-1:0] v);
    return (v == '0) ? LOW_W'(1) : v;
  endfunction

  function automatic logic [BANK_W-1:0] wrap_bank(input logic [BANK_W-1:0] b,
                                                  input int unsigned banks);
    return b & BANK_W'(banks - 1);
  endfunction
endpackage

// File: rtl/bank_mapper_decode.sv
module bank_mapper_decode
  import bank_mapper_pkg::*;
(
  input  logic            wr_en,
  input  logic [2:0]      addr_top,
  output logic [NRGN-1:0] wr_rgn,
  output logic            in_ram_win
);
  for (genvar g = 0; g < NRGN; g++) begin : g_rgn
    assign wr_rgn[g] = wr_en && !addr_top[2] && (addr_top[1:0] == 2'(g));
  end
  assign in_ram_win = (addr_top == RAM_WIN);
endmodule

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs
  import bank_mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NRGN-1:0]   wr_rgn,
  input  logic [7:0]        wdata,
  output logic              ram_en_q,
  output logic              mode_q,
  output logic [BANK_W-1:0] rom_bank_raw,
  output logic [RSEL_W-1:0] ram_bank_q
);
  logic [LOW_W-1:0] lo_q;
  logic [HI_W-1:0]  hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_en_q   <= 1'b0;
      mode_q     <= 1'b0;
      lo_q       <= LOW_W'(1);
      hi_q       <= '0;
      ram_bank_q <= '0;
    end else begin
      if (wr_rgn[0]) begin
        if (wdata == EN_KEY)       ram_en_q <= 1'b1;
        else if (wdata == DIS_KEY) ram_en_q <= 1'b0;
      end
      if (wr_rgn[1]) lo_q <= fix_low(wdata[LOW_W-1:0]);
      if (wr_rgn[2]) begin
        if (mode_q) ram_bank_q <= wdata[RSEL_W-1:0];
        else        hi_q       <= wdata[HI_W-1:0];
      end
      if (wr_rgn[3]) begin
        mode_q <= wdata[0];
        if (wdata[0]) hi_q       <= '0;
        else          ram_bank_q <= '0;
      end
    end
  end

  assign rom_bank_raw = {hi_q, lo_q};
endmodule

// File: rtl/bank_mapper_wrap.sv
module bank_mapper_wrap
  import bank_mapper_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 64
) (
  input  logic [BANK_W-1:0] raw,
  output logic [BANK_W-1:0] eff
);
  assign eff = wrap_bank(raw, ROM_BANKS);
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr_top,
  input  logic [7:0]        wdata,
  output logic [BANK_W-1:0] rom_bank_o,
  output logic [RSEL_W-1:0] ram_bank_o,
  output logic              ram_ce_o
);
  logic [NRGN-1:0]   wr_rgn;
  logic              in_ram_win;
  logic              ram_en_q;
  logic              mode_q;
  logic [BANK_W-1:0] rom_bank_raw;

  bank_mapper_decode u_dec (
    .wr_en(wr_en), .addr_top(addr_top), .wr_rgn(wr_rgn), .in_ram_win(in_ram_win)
  );

  bank_mapper_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_rgn(wr_rgn), .wdata(wdata),
    .ram_en_q(ram_en_q), .mode_q(mode_q), .rom_bank_raw(rom_bank_raw),
    .ram_bank_q(ram_bank_o)
  );

  bank_mapper_wrap #(.ROM_BANKS(ROM_BANKS)) u_wrap (
    .raw(rom_bank_raw), .eff(rom_bank_o)
  );

  assign ram_ce_o = ram_en_q && in_ram_win;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
  import bank_mapper_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NRGN-1:0]   wr_rgn,
  input logic [7:0]        wdata,
  input logic [2:0]        addr_top,
  input logic              ram_en_q,
  input logic              mode_q,
  input logic [BANK_W-1:0] rom_bank_raw,
  input logic [RSEL_W-1:0] ram_bank_o,
  input logic              ram_ce_o
);
  p_onehot_rgn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_rgn));
  p_enable_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rgn[0] && wdata == 8'h0A) |=> ram_en_q);
  p_disable_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rgn[0] && wdata == 8'h00) |=> !ram_en_q);
  p_low_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rgn[1] && wdata[4:0] != 5'd0) |=> rom_bank_raw[4:0] == $past(wdata[4:0]));
  p_hi_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rgn[1] |=> rom_bank_raw[6:5] == $past(rom_bank_raw[6:5]));
  p_low_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bank_raw[4:0] != 5'd0);
  p_ram_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rgn[2] && mode_q) |=> (ram_bank_o == $past(wdata[1:0])) && $stable(rom_bank_raw));
  p_mode1_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rgn[3] && wdata[0]) |=> (rom_bank_raw[6:5] == 2'd0) && mode_q);
  p_mode0_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rgn[3] && !wdata[0]) |=> (ram_bank_o == 2'd0) && !mode_q);
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rgn == '0) |=> $stable(rom_bank_raw) && $stable(ram_bank_o) && $stable(ram_en_q));
  p_ce_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce_o |-> (addr_top == 3'b101) && ram_en_q);
endmodule

bind bank_mapper bank_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_rgn(wr_rgn), .wdata(wdata), .addr_top(addr_top),
  .ram_en_q(ram_en_q), .mode_q(mode_q), .rom_bank_raw(rom_bank_raw),
  .ram_bank_o(ram_bank_o), .ram_ce_o(ram_ce_o)
);

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;
  localparam int unsigned BANKS = 64;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [15:0] cpu_addr = 16'h4000;
  logic [7:0] wdata = 8'h00;
  logic [6:0] rom_bank_o;
  logic [1:0] ram_bank_o;
  logic       ram_ce_o;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bank_mapper #(.ROM_BANKS(BANKS)) u_bank_mapper (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_top(cpu_addr[15:13]),
    .wdata(wdata), .rom_bank_o(rom_bank_o), .ram_bank_o(ram_bank_o), .ram_ce_o(ram_ce_o)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cpu_addr = 16'h4000; wdata = 8'h00;
  endtask

  task automatic peek_ce(input logic [15:0] a, input string req, input int exp);
    @(negedge clk);
    cpu_addr = a;
    #1;
    check(req, int'(ram_ce_o), exp);
    cpu_addr = 16'h4000;
  endtask

  task automatic t_reset();
    check("R1 rom bank", int'(rom_bank_o), 1);
    check("R1 ram bank", int'(ram_bank_o), 0);
    peek_ce(16'hA000, "R1 ram disabled", 0);
  endtask

  task automatic t_enable();
    cpu_write(16'h0000, 8'h0A);
    peek_ce(16'hA123, "R2 enable 0x0A", 1);
    cpu_write(16'h1FFF, 8'h55);
    peek_ce(16'hBFFF, "R2 other value keeps enable", 1);
    peek_ce(16'hC000, "R10 above window", 0);
    peek_ce(16'h9FFF, "R10 below window", 0);
    cpu_write(16'h0000, 8'h00);
    peek_ce(16'hA000, "R2 disable 0x00", 0);
    cpu_write(16'h0000, 8'h3A);
    peek_ce(16'hA000, "R2 other value keeps disable", 0);
  endtask

  task automatic t_low();
    cpu_write(16'h2000, 8'hE7);
    check("R3 low bits, upper data ignored", int'(rom_bank_o), 7);
    cpu_write(16'h3000, 8'h00);
    check("R4 zero becomes one", int'(rom_bank_o), 1);
    cpu_write(16'h2000, 8'h20);
    check("R4 low five zero with bit5 set", int'(rom_bank_o), 1);
  endtask

  task automatic t_upper();
    cpu_write(16'h4000, 8'h03);
    check("R5 R9 hi bits wrapped", int'(rom_bank_o), 8'h61 & (BANKS - 1));
    check("R5 ram bank untouched", int'(ram_bank_o), 0);
    cpu_write(16'h2000, 8'h1F);
    check("R3 R9 hi kept, 0x7F wrapped", int'(rom_bank_o), 8'h7F & (BANKS - 1));
  endtask

  task automatic t_mode();
    cpu_write(16'h6000, 8'h01);
    check("R7 mode1 clears hi", int'(rom_bank_o), 8'h1F);
    cpu_write(16'h4000, 8'h02);
    check("R6 ram bank select", int'(ram_bank_o), 2);
    check("R6 rom unchanged", int'(rom_bank_o), 8'h1F);
    cpu_write(16'h6000, 8'h01);
    check("R7 ram bank kept", int'(ram_bank_o), 2);
    cpu_write(16'h6000, 8'h00);
    check("R8 mode0 zeroes ram bank", int'(ram_bank_o), 0);
    check("R8 rom kept", int'(rom_bank_o), 8'h1F);
    cpu_write(16'h4000, 8'h01);
    check("R5 back in mode0 hi loaded", int'(rom_bank_o), 8'h3F & (BANKS - 1));
  endtask

  task automatic t_ignore();
    cpu_write(16'hA000, 8'h0A);
    peek_ce(16'hA000, "R11 upper-half write no enable", 0);
    cpu_write(16'hC000, 8'h03);
    check("R11 upper-half write rom", int'(rom_bank_o), 8'h3F);
    @(negedge clk);
    cpu_addr = 16'h2000; wdata = 8'h05; wr_en = 1'b0;
    @(negedge clk);
    cpu_addr = 16'h4000;
    check("R11 strobe low rom", int'(rom_bank_o), 8'h3F);
    check("R11 strobe low ram", int'(ram_bank_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_low();
    t_upper();
    t_mode();
    t_ignore();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule